// File: doc/BRIEF.md
# Slotted Ring Station Node

This block is one stop on a synchronous, one-way slotted ring. On every clock it takes one slot from the upstream neighbour and, one cycle later, hands one slot to the downstream neighbour. A slot is either empty or carries a single packet: an 8-bit routing mask, a 4-bit transfer tag and a 32-bit payload.

The node inspects the station field of each arriving mask. If the bit for its own position is set, the node delivers the packet to its local station through a valid/ready port. A packet addressed only to this node is taken off the ring, and an empty slot goes downstream in its place. A packet that also names other stations is delivered and also sent onward, with this node's bit cleared. If the receive port is still holding an undelivered packet, an arriving packet for this node stays on the ring unchanged and comes round again later.

The station hands outgoing packets to a small queue through a valid/ready port. The node places the oldest queued packet on the ring only when the incoming slot is empty. A slot that the node has just freed is not reused in the same cycle.

Top module: `ring_node`

## Requirements
- R1: After reset the output slot is empty (out_valid=0), rx_valid is 0 and tx_ready is 1.
- R2: A valid incoming slot whose station-field bit (mask bit NODE_ID, station field = mask[3:0]) is clear appears unchanged on the output exactly one cycle later.
- R3: A valid slot whose station field has only this node's bit set, arriving while the receive port has room (rx_valid=0 or rx_ready=1), is presented on rx one cycle later, and the output slot in that cycle is empty, even when the transmit queue holds packets.
- R4: A valid slot with this node's bit set and at least one other station bit set, arriving while the receive port has room, is presented on rx and also forwarded one cycle later with only this node's bit cleared. Ring field, tag and payload are unchanged.
- R5: A slot for this node that arrives while rx_valid=1 and rx_ready=0 is forwarded unchanged, and the held rx packet is not replaced.
- R6: A queued packet is inserted only when the incoming slot is empty. While valid slots keep arriving, nothing is inserted.
- R7: The transmit queue holds 4 packets. tx_ready is 0 while it is full. Queued packets leave in arrival order, and an offer made while tx_ready=0 is not taken.
- R8: While rx_valid=1 and rx_ready=0, rx_valid, rx_mask, rx_tid and rx_data hold steady. After a transfer with no new packet, rx_valid drops.
- R9: An incoming slot with in_valid=0 is treated as empty whatever its other fields hold. With the queue empty, it yields an empty output and no delivery.
- R10: The ring field (mask[7:4]) plays no part in matching and is carried through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming slot occupied |
| in_mask | input | 8 | Incoming routing mask (ring field [7:4], station field [3:0]) |
| in_tid | input | 4 | Incoming transfer tag |
| in_data | input | 32 | Incoming payload |
| out_valid | output | 1 | Outgoing slot occupied |
| out_mask | output | 8 | Outgoing routing mask |
| out_tid | output | 4 | Outgoing transfer tag |
| out_data | output | 32 | Outgoing payload |
| tx_valid | input | 1 | Station offers a packet to send |
| tx_ready | output | 1 | Transmit queue can accept |
| tx_mask | input | 8 | Mask of offered packet |
| tx_tid | input | 4 | Tag of offered packet |
| tx_data | input | 32 | Payload of offered packet |
| rx_valid | output | 1 | Delivered packet present |
| rx_ready | input | 1 | Station takes delivered packet |
| rx_mask | output | 8 | Mask of delivered packet |
| rx_tid | output | 4 | Tag of delivered packet |
| rx_data | output | 32 | Payload of delivered packet |

## Verification
The bench drives all 256 mask values through a node at position 2 with the receive port ready. This separates pass-through, unicast removal and multicast copy, and shows that ring-field bits never change the match. Runs of valid slots with a filled queue show that nothing is inserted into occupied slots, and that the queue fill limit holds. A following run of empty slots shows the queued packets leave in order. Holding rx_ready low shows that a second packet for the node goes round again instead of overwriting the first. A queued packet alongside a unicast removal shows that a freed slot is not reused in the same cycle.

// File: rtl/ring_node_pkg.sv
package ring_node_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_PASS,
    ACT_INSERT,
    ACT_TAKE_FREE,
    ACT_TAKE_COPY
  } slot_act_e;
endpackage

// File: rtl/ring_node_route.sv
module ring_node_route
  import ring_node_pkg::*;
#(
  parameter int MASK_W  = 8,
  parameter int STN_W   = 4,
  parameter int NODE_ID = 0
) (
  input  logic              in_valid,
  input  logic [MASK_W-1:0] in_mask,
  input  logic              q_nonempty,
  input  logic              rx_room,
  output slot_act_e         act,
  output logic [MASK_W-1:0] fwd_mask
);
  localparam logic [MASK_W-1:0] OWN_BIT = MASK_W'(1) << NODE_ID;
  localparam logic [STN_W-1:0]  OWN_STN = OWN_BIT[STN_W-1:0];

  logic hit, others;

  always_comb begin
    hit      = in_valid && in_mask[NODE_ID];
    others   = |(in_mask[STN_W-1:0] & ~OWN_STN);
    fwd_mask = in_mask & ~OWN_BIT;
    if (!in_valid)
      act = q_nonempty ? ACT_INSERT : ACT_IDLE;
    else if (hit && rx_room)
      act = others ? ACT_TAKE_COPY : ACT_TAKE_FREE;
    else
      act = ACT_PASS;
  end
endmodule

// File: rtl/ring_node_txq.sv
module ring_node_txq #(
  parameter int W     = 44,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         nonempty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign full     = (count == CW'(DEPTH));
  assign nonempty = (count != '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && nonempty;
  assign rdata    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/ring_node_rxbuf.sv
module ring_node_rxbuf #(
  parameter int W = 44
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] ldata,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data,
  output logic         room
);
  assign room = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= ldata;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ring_node.sv
module ring_node
  import ring_node_pkg::*;
#(
  parameter int MASK_W   = 8,
  parameter int STN_W    = 4,
  parameter int TID_W    = 4,
  parameter int DATA_W   = 32,
  parameter int TX_DEPTH = 4,
  parameter int NODE_ID  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [MASK_W-1:0] in_mask,
  input  logic [TID_W-1:0]  in_tid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [MASK_W-1:0] out_mask,
  output logic [TID_W-1:0]  out_tid,
  output logic [DATA_W-1:0] out_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [MASK_W-1:0] tx_mask,
  input  logic [TID_W-1:0]  tx_tid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [MASK_W-1:0] rx_mask,
  output logic [TID_W-1:0]  rx_tid,
  output logic [DATA_W-1:0] rx_data
);
  localparam int PKT_W = MASK_W + TID_W + DATA_W;

  slot_act_e         act;
  logic [MASK_W-1:0] fwd_mask;
  logic              q_full, q_nonempty, rx_room, rx_load;
  logic [PKT_W-1:0]  q_head, rx_word;

  ring_node_route #(.MASK_W(MASK_W), .STN_W(STN_W), .NODE_ID(NODE_ID)) route_i (
    .in_valid  (in_valid),
    .in_mask   (in_mask),
    .q_nonempty(q_nonempty),
    .rx_room   (rx_room),
    .act       (act),
    .fwd_mask  (fwd_mask)
  );

  ring_node_txq #(.W(PKT_W), .DEPTH(TX_DEPTH)) txq_i (
    .clk     (clk),
    .rst     (rst),
    .push    (tx_valid),
    .wdata   ({tx_mask, tx_tid, tx_data}),
    .pop     (act == ACT_INSERT),
    .rdata   (q_head),
    .full    (q_full),
    .nonempty(q_nonempty)
  );

  assign tx_ready = !q_full;
  assign rx_load  = (act == ACT_TAKE_FREE) || (act == ACT_TAKE_COPY);

  ring_node_rxbuf #(.W(PKT_W)) rxbuf_i (
    .clk  (clk),
    .rst  (rst),
    .load (rx_load),
    .ldata({in_mask, in_tid, in_data}),
    .ready(rx_ready),
    .valid(rx_valid),
    .data (rx_word),
    .room (rx_room)
  );

  assign {rx_mask, rx_tid, rx_data} = rx_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_mask  <= '0;
      out_tid   <= '0;
      out_data  <= '0;
    end else begin
      unique case (act)
        ACT_PASS: begin
          out_valid <= 1'b1;
          out_mask  <= in_mask;
          out_tid   <= in_tid;
          out_data  <= in_data;
        end
        ACT_TAKE_COPY: begin
          out_valid <= 1'b1;
          out_mask  <= fwd_mask;
          out_tid   <= in_tid;
          out_data  <= in_data;
        end
        ACT_INSERT: begin
          out_valid <= 1'b1;
          {out_mask, out_tid, out_data} <= q_head;
        end
        default: begin
          out_valid <= 1'b0;
          out_mask  <= '0;
          out_tid   <= '0;
          out_data  <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ring_node_chk.sv
module ring_node_chk #(
  parameter int MASK_W   = 8,
  parameter int STN_W    = 4,
  parameter int TID_W    = 4,
  parameter int DATA_W   = 32,
  parameter int TX_DEPTH = 4,
  parameter int NODE_ID  = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [MASK_W-1:0] in_mask,
  input logic [TID_W-1:0]  in_tid,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [MASK_W-1:0] out_mask,
  input logic [TID_W-1:0]  out_tid,
  input logic [DATA_W-1:0] out_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [MASK_W-1:0] rx_mask,
  input logic [TID_W-1:0]  rx_tid,
  input logic [DATA_W-1:0] rx_data
);
  localparam logic [MASK_W-1:0] OWN_BIT = MASK_W'(1) << NODE_ID;
  localparam logic [MASK_W-1:0] STN_ALL = MASK_W'((1 << STN_W) - 1);

  logic hit, room, multi;
  assign hit   = in_valid && in_mask[NODE_ID];
  assign room  = !rx_valid || rx_ready;
  assign multi = |(in_mask & STN_ALL & ~OWN_BIT);

  a_r2_pass: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_mask[NODE_ID]) |=>
      (out_valid && out_mask == $past(in_mask) && out_tid == $past(in_tid)
       && out_data == $past(in_data)));

  a_r3_free: assert property (@(posedge clk) disable iff (rst)
    (hit && room && !multi) |=>
      (!out_valid && rx_valid && rx_data == $past(in_data)));

  a_r4_copy: assert property (@(posedge clk) disable iff (rst)
    (hit && room && multi) |=>
      (out_valid && rx_valid && out_mask == ($past(in_mask) & ~OWN_BIT)
       && out_data == $past(in_data)));

  a_r5_recirc: assert property (@(posedge clk) disable iff (rst)
    (hit && !room) |=> (out_valid && out_mask == $past(in_mask)));

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_ready) |=>
      (rx_valid && $stable(rx_mask) && $stable(rx_tid) && $stable(rx_data)));
endmodule

bind ring_node ring_node_chk #(
  .MASK_W(MASK_W), .STN_W(STN_W), .TID_W(TID_W), .DATA_W(DATA_W),
  .TX_DEPTH(TX_DEPTH), .NODE_ID(NODE_ID)
) chk_i (.*);

// File: tb/ring_node_tb_top.sv
module ring_node_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NODE = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_mask = '0;
  logic [3:0]  in_tid = '0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [7:0]  out_mask;
  logic [3:0]  out_tid;
  logic [31:0] out_data;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [7:0]  tx_mask = '0;
  logic [3:0]  tx_tid = '0;
  logic [31:0] tx_data = '0;
  logic        rx_valid;
  logic        rx_ready = 1'b1;
  logic [7:0]  rx_mask;
  logic [3:0]  rx_tid;
  logic [31:0] rx_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ring_node #(.NODE_ID(NODE)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1", out_valid, 0);
    chk(rx_valid == 1'b0, "R1", rx_valid, 0);
    chk(tx_ready == 1'b1, "R1", tx_ready, 1);

    // Sweep every mask value with the receive side ready
    for (int m = 0; m < 256; m++) begin
      logic [7:0] mk, fwd;
      bit hit, others;
      mk = 8'(m);
      in_valid = 1'b1; in_mask = mk; in_tid = 4'(m); in_data = 32'hC000_0000 + 32'(m);
      @(negedge clk);
      hit    = mk[NODE];
      others = (mk[3:0] & ~(4'b1 << NODE)) != 0;
      fwd    = mk & ~(8'b1 << NODE);
      if (!hit) begin
        chk(out_valid && out_mask == mk && out_tid == 4'(m) && out_data == in_data,
            "R2", {out_valid, out_mask}, {1'b1, mk});
        chk(!rx_valid, "R2", rx_valid, 0);
      end else begin
        chk(rx_valid && rx_mask == mk && rx_data == in_data && rx_tid == 4'(m),
            others ? "R4" : "R3", {rx_valid, rx_mask}, {1'b1, mk});
        if (others)
          chk(out_valid && out_mask == fwd && out_data == in_data, "R4",
              {out_valid, out_mask}, {1'b1, fwd});
        else
          chk(!out_valid, "R3", out_valid, 0);
        if (mk[7:4] != 0) chk(rx_mask[7:4] == mk[7:4], "R10", rx_mask, mk);
      end
    end

    // R9: invalid slot with own bit set
    in_valid = 1'b0; in_mask = 8'h1F; in_data = 32'hDEAD;
    @(negedge clk);
    chk(!out_valid, "R9", out_valid, 0);
    chk(!rx_valid, "R9", rx_valid, 0);

    // R6/R7: fill queue while valid non-hit slots stream past
    in_valid = 1'b1; in_mask = 8'h01; in_data = 32'h5555;
    for (int i = 0; i < 5; i++) begin
      chk(tx_ready == (i < 4), "R7", tx_ready, (i < 4));
      tx_valid = 1'b1; tx_mask = 8'h18; tx_tid = 4'(i); tx_data = 32'hA0 + 32'(i);
      @(negedge clk);
      chk(out_valid && out_mask == 8'h01 && out_data == 32'h5555, "R6", out_mask, 8'h01);
    end
    tx_valid = 1'b0;
    chk(!tx_ready, "R7", tx_ready, 0);

    // R6/R7: empty slots take queue in order
    in_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(out_valid && out_data == 32'hA0 + 32'(i) && out_tid == 4'(i),
          "R7", out_data, 32'hA0 + 32'(i));
    end
    chk(tx_ready, "R7", tx_ready, 1);
    @(negedge clk);
    chk(!out_valid, "R9", out_valid, 0);

    // R3: freed slot is not refilled in the same cycle
    tx_valid = 1'b1; tx_mask = 8'h12; tx_tid = 4'h7; tx_data = 32'hBEEF;
    @(negedge clk);
    tx_valid = 1'b0;
    in_valid = 1'b1; in_mask = 8'h04; in_data = 32'h1234;
    @(negedge clk);
    chk(!out_valid, "R3", out_valid, 0);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid && out_data == 32'hBEEF, "R6", out_data, 32'hBEEF);

    // R5/R8: receive port stalled
    rx_ready = 1'b0;
    in_valid = 1'b1; in_mask = 8'h04; in_data = 32'h1111;
    @(negedge clk);
    chk(rx_valid && rx_data == 32'h1111, "R3", rx_data, 32'h1111);
    in_mask = 8'h0C; in_data = 32'h2222;
    @(negedge clk);
    chk(out_valid && out_mask == 8'h0C && out_data == 32'h2222, "R5", out_mask, 8'h0C);
    chk(rx_valid && rx_data == 32'h1111 && rx_mask == 8'h04, "R8", rx_data, 32'h1111);
    in_valid = 1'b0;
    @(negedge clk);
    chk(rx_valid && rx_data == 32'h1111, "R8", rx_data, 32'h1111);
    rx_ready = 1'b1;
    @(negedge clk);
    chk(!rx_valid, "R8", rx_valid, 0);

    finish_run();
  end
endmodule